// File: doc/BRIEF.md
# External Static Memory Bank Timing Controller

This block drives the control strobes of an external static memory bus shared by up to eight banks, for example ROM, SRAM, flash or memory-mapped I/O. It takes one request at a time from an internal request interface. The interface carries an address, a read/write flag, byte enables and write data. The block then runs a fixed sequence of bus phases on the external pins and returns a one-cycle completion pulse, together with the read data.

Each bank has its own 14-bit timing word, written through a small configuration port. The timing word sets four phase lengths:
- an address-only lead-in,
- a chip-select-before-strobe lead-in,
- the strobe length,
- a chip-select tail after the strobe.

A bank can be flagged as ROM type. For such a bank the strobe rises together with its chip select. An active-low wait input from the device can stretch the strobe past the programmed length, with no upper bound. The bus width of bank 0 comes from two strap pins. Every other bank takes its width from its timing word. Each access is a single external beat.

Top module: `smc_bank_timer`

## Requirements
- R1: After reset, all chip selects, the output-enable strobe and all write strobes are high (inactive), `req_ready` is 1 and `rsp_done` is 0. Every timing word resets to all-ones fields: address lead 3, select lead 3, strobe 31, tail 3, ROM flag 1, width 2'b11.
- R2: The bank is `req_addr[26:24]`. While an access runs, the only chip select that may go low is `mem_cs_n[bank]`, and at most one chip select is low in any cycle.
- R3: After acceptance, the address is driven for `tacs` cycles (word bits [1:0]) with no chip select and no strobe.
- R4: For a bank with word bit [11] = 0, the chip select is low for `tcos` cycles (bits [3:2]) before the strobe starts. For a bank with bit [11] = 1 this phase is skipped, so the strobe and the chip select go low in the same cycle.
- R5: With `mem_wait_n` high, the strobe stays active for `tacc` cycles (bits [8:4]). A value of 0 gives one cycle.
- R6: `mem_wait_n` is sampled on the last programmed strobe cycle and on every cycle after it. The strobe ends with the first sampled cycle in which `mem_wait_n` is high, so accesses longer than 31 cycles are possible.
- R7: After the strobe, the chip select stays low with no strobe for `tcoh` cycles (bits [10:9]).
- R8: `rsp_done` is high for exactly one cycle, in the cycle right after the last chip-select cycle. In that cycle `rsp_rdata` holds `mem_din` as sampled in the last strobe cycle of a read. In the next cycle `req_ready` is 1.
- R9: A write drives `mem_we_n[i]` low only for the lanes with `req_be[i]` = 1 and keeps `mem_oe_n` high. A read drives `mem_oe_n` low and keeps every `mem_we_n` high. During a write, `mem_dout_en` is 1 and `mem_dout` equals the write data from the first cycle after acceptance through the last chip-select cycle. During a read, `mem_dout_en` stays 0.
- R10: While the chip select is low, `mem_width` shows the width of the bank: for bank 0, the strap pins as they were at acceptance (01 = 8-bit, 10 = 16-bit, 11 = 32-bit); for the other banks, word bits [13:12].
- R11: A request presented while `req_ready` is 0 is ignored. It starts no access and changes no chip select.
- R12: A configuration write (`cfg_wr` with `cfg_bank`, `cfg_data`) takes effect for accesses accepted after the write's clock edge. An access accepted on the same edge uses the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Timing word write strobe |
| cfg_bank | input | 3 | Bank whose timing word is written |
| cfg_data | input | 14 | New timing word |
| strap_width0 | input | 2 | Bank 0 bus width straps |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Request address, bits [26:24] select the bank |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| mem_addr | output | 27 | External address |
| mem_cs_n | output | 8 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 4 | Active-low per-lane write strobes |
| mem_dout | output | 32 | External write data |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | 32 | External read data |
| mem_wait_n | input | 1 | Active-low wait from the device |
| mem_width | output | 2 | Bus width of the bank in use |

## Verification
Two events can land on the same clock edge: a timing-word write and the acceptance of a request to that same bank. The bench provokes this by raising `cfg_wr` and `req_valid` in the same cycle, with a new word whose phase lengths differ from the old one. It judges the result by the phase lengths it measures on the pins. The access accepted on that edge must follow the old word, and the next access to that bank must follow the new one.

// File: rtl/smc_pkg.sv
package smc_pkg;

    // Per-bank timing word; field positions are fixed by the configuration format.
    typedef struct packed {
        logic [1:0] width;   // [13:12]
        logic       rom;     // [11]
        logic [1:0] tcoh;    // [10:9]
        logic [4:0] tacc;    // [8:4]
        logic [1:0] tcos;    // [3:2]
        logic [1:0] tacs;    // [1:0]
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    localparam bank_cfg_t CFG_RESET = '{width: 2'b11, rom: 1'b1, tcoh: 2'd3,
                                        tacc: 5'd31, tcos: 2'd3, tacs: 2'd3};

    // Order matters: phase_enter walks forward from a given phase.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_COS  = 3'd2,
        PH_ACC  = 3'd3,
        PH_WAIT = 3'd4,
        PH_HOLD = 3'd5,
        PH_DONE = 3'd6
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [4:0] cnt;
        bank_cfg_t  cfg;
    } seq_state_t;

    // First phase at or after 'from' whose programmed length is non-zero.
    function automatic seq_state_t phase_enter(phase_e from, bank_cfg_t c);
        seq_state_t s;
        s.cfg = c;
        s.cnt = '0;
        s.ph  = PH_DONE;
        if (from <= PH_ADDR && c.tacs != 2'd0) begin
            s.ph  = PH_ADDR;
            s.cnt = {3'd0, c.tacs - 2'd1};
        end else if (from <= PH_COS && !c.rom && c.tcos != 2'd0) begin
            s.ph  = PH_COS;
            s.cnt = {3'd0, c.tcos - 2'd1};
        end else if (from <= PH_ACC) begin
            s.ph  = PH_ACC;
            s.cnt = (c.tacc == 5'd0) ? 5'd0 : c.tacc - 5'd1;
        end else if (c.tcoh != 2'd0) begin
            s.ph  = PH_HOLD;
            s.cnt = {3'd0, c.tcoh - 2'd1};
        end
        return s;
    endfunction

endpackage

// File: rtl/smc_cfg_file.sv
module smc_cfg_file
    import smc_pkg::*;
#(
    parameter int NBANK = 8,
    localparam int SELW = $clog2(NBANK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  bank_cfg_t       wr_cfg,
    input  logic [SELW-1:0] rd_sel,
    output bank_cfg_t       rd_cfg
);

    bank_cfg_t regs_d [NBANK];
    bank_cfg_t regs_q [NBANK];

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            regs_d[b] = regs_q[b];
            if (wr_en && wr_sel == SELW'(b)) begin
                regs_d[b] = wr_cfg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) begin
                regs_q[b] <= CFG_RESET;
            end
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                regs_q[b] <= regs_d[b];
            end
        end
    end

    assign rd_cfg = regs_q[rd_sel];

endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  bank_cfg_t start_cfg,
    input  logic      wait_n,
    output phase_e    phase,
    output logic      capture
);

    seq_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        capture = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d = phase_enter(PH_ADDR, start_cfg);
                end
            end
            PH_ADDR: begin
                if (s_q.cnt == 5'd0) s_d = phase_enter(PH_COS, s_q.cfg);
                else                 s_d.cnt = s_q.cnt - 5'd1;
            end
            PH_COS: begin
                if (s_q.cnt == 5'd0) s_d = phase_enter(PH_ACC, s_q.cfg);
                else                 s_d.cnt = s_q.cnt - 5'd1;
            end
            PH_ACC: begin
                if (s_q.cnt != 5'd0) begin
                    s_d.cnt = s_q.cnt - 5'd1;
                end else if (wait_n) begin
                    capture = 1'b1;
                    s_d     = phase_enter(PH_HOLD, s_q.cfg);
                end else begin
                    s_d.ph = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (wait_n) begin
                    capture = 1'b1;
                    s_d     = phase_enter(PH_HOLD, s_q.cfg);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == 5'd0) s_d.ph = PH_DONE;
                else                 s_d.cnt = s_q.cnt - 5'd1;
            end
            PH_DONE: begin
                s_d.ph = PH_IDLE;
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: 5'd0, cfg: CFG_RESET};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;

endmodule

// File: rtl/smc_bank_timer.sv
module smc_bank_timer
    import smc_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int AW    = 27,
    parameter int DW    = 32,
    localparam int SELW = $clog2(NBANK),
    localparam int BEW  = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SELW-1:0]  cfg_bank,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [1:0]       strap_width0,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [BEW-1:0]   req_be,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] mem_cs_n,
    output logic             mem_oe_n,
    output logic [BEW-1:0]   mem_we_n,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dout_en,
    input  logic [DW-1:0]    mem_din,
    input  logic             mem_wait_n,
    output logic [1:0]       mem_width
);

    typedef struct packed {
        logic [SELW-1:0] bank;
        logic [AW-1:0]   addr;
        logic            write;
        logic [BEW-1:0]  be;
        logic [DW-1:0]   wdata;
        logic [1:0]      width;
        logic [DW-1:0]   rdata;
    } xfer_t;

    xfer_t           x_d, x_q;
    logic [SELW-1:0] req_bank;
    bank_cfg_t       sel_cfg;
    phase_e          ph;
    logic            capture;
    logic            go;
    logic            cs_on;
    logic            strobe_on;

    assign req_bank = req_addr[AW-1 -: SELW];
    assign go       = req_valid && req_ready;

    smc_cfg_file #(.NBANK(NBANK)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wr_sel (cfg_bank),
        .wr_cfg (bank_cfg_t'(cfg_data)),
        .rd_sel (req_bank),
        .rd_cfg (sel_cfg)
    );

    smc_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .start_cfg (sel_cfg),
        .wait_n    (mem_wait_n),
        .phase     (ph),
        .capture   (capture)
    );

    always_comb begin
        x_d = x_q;
        if (go) begin
            x_d.bank  = req_bank;
            x_d.addr  = req_addr;
            x_d.write = req_write;
            x_d.be    = req_be;
            x_d.wdata = req_wdata;
            x_d.width = (req_bank == SELW'(0)) ? strap_width0 : sel_cfg.width;
        end
        if (capture && !x_q.write) begin
            x_d.rdata = mem_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign cs_on     = ph inside {PH_COS, PH_ACC, PH_WAIT, PH_HOLD};
    assign strobe_on = ph inside {PH_ACC, PH_WAIT};

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign mem_cs_n[b] = !(cs_on && (x_q.bank == SELW'(b)));
    end

    assign mem_oe_n    = !(strobe_on && !x_q.write);
    assign mem_we_n    = ~({BEW{strobe_on && x_q.write}} & x_q.be);
    assign mem_dout_en = x_q.write && (ph != PH_IDLE) && (ph != PH_DONE);
    assign mem_dout    = x_q.wdata;
    assign mem_addr    = x_q.addr;
    assign mem_width   = x_q.width;
    assign req_ready   = (ph == PH_IDLE);
    assign rsp_done    = (ph == PH_DONE);
    assign rsp_rdata   = x_q.rdata;

endmodule

// File: rtl/smc_bank_timer_chk.sv
module smc_bank_timer_chk #(
    parameter int NBANK = 8,
    parameter int BEW   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] mem_cs_n,
    input logic             mem_oe_n,
    input logic [BEW-1:0]   mem_we_n,
    input logic             mem_dout_en,
    input logic             req_ready,
    input logic             rsp_done
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n && mem_oe_n && &mem_we_n));

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !(&mem_we_n)) |-> !(&mem_cs_n));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready);

    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> &mem_we_n);

    assert_write_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_we_n) |-> mem_dout_en);

endmodule

bind smc_bank_timer smc_bank_timer_chk #(.NBANK(NBANK), .BEW(BEW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout_en (mem_dout_en),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done)
);

// File: tb/smc_bank_timer_tb_top.sv
module smc_bank_timer_tb_top;
    import smc_pkg::*;

    localparam int NB  = 8;
    localparam int AW  = 27;
    localparam int DW  = 32;
    localparam int BEW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_bank = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic [1:0]       strap_width0 = 2'b11;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [BEW-1:0]   req_be = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic             rsp_done;
    logic [DW-1:0]    rsp_rdata;
    logic [AW-1:0]    mem_addr;
    logic [NB-1:0]    mem_cs_n;
    logic             mem_oe_n;
    logic [BEW-1:0]   mem_we_n;
    logic [DW-1:0]    mem_dout;
    logic             mem_dout_en;
    logic [DW-1:0]    mem_din = '0;
    logic             mem_wait_n = 1'b1;
    logic [1:0]       mem_width;

    always #10 clk = ~clk;

    smc_bank_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
        .cfg_data(cfg_data), .strap_width0(strap_width0), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait_n(mem_wait_n),
        .mem_width(mem_width)
    );

    typedef struct {
        int         bank;
        bit         write;
        logic [3:0] be;
        logic [31:0] wdata;
        logic [26:0] addr;
        int         tacs;
        int         tcos;
        int         strobe;
        int         hold;
        logic [31:0] rdata;
        logic [1:0] width;
        string      stag;
    } exp_t;

    exp_t       sb_q[$];
    bank_cfg_t  cfgm [NB];
    int         n_chk = 0;
    int         n_bad = 0;
    int         n_done = 0;
    int         n_sent = 0;
    logic [31:0] din_base = '0;
    int         wait_target = 0;

    int a_cnt = 0, c_cnt = 0, s_cnt = 0, h_cnt = 0;
    bit bad_cs = 0, bad_width = 0, bad_dout = 0, bad_sig = 0, bad_addr = 0;

    task automatic compare(string req, string what, longint act, longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: classify each cycle of an access and score it when done pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_done) begin
                n_done++;
                if (sb_q.size() == 0) begin
                    compare("R11", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    compare("R3", "address lead cycles", a_cnt, e.tacs);
                    compare("R4", "select lead cycles", c_cnt, e.tcos);
                    compare(e.stag, "strobe cycles", s_cnt, e.strobe);
                    compare("R7", "select tail cycles", h_cnt, e.hold);
                    compare("R2", "chip select bank", bad_cs, 0);
                    compare("R10", "bus width", bad_width, 0);
                    compare("R9", "strobe lanes", bad_sig, 0);
                    compare("R9", "write data drive", bad_dout, 0);
                    compare("R2", "address out", bad_addr, 0);
                    if (!e.write) compare("R8", "read data", rsp_rdata, e.rdata);
                end
                a_cnt = 0; c_cnt = 0; s_cnt = 0; h_cnt = 0;
                bad_cs = 0; bad_width = 0; bad_dout = 0; bad_sig = 0; bad_addr = 0;
                mem_wait_n = 1'b1;
            end else if (!req_ready && sb_q.size() != 0) begin
                exp_t e;
                bit   strobe;
                e = sb_q[0];
                strobe = !mem_oe_n || (mem_we_n != 4'hF);
                if (mem_addr != e.addr) bad_addr = 1;
                if (mem_cs_n != 8'hFF) begin
                    if (mem_cs_n != ~(8'h01 << e.bank)) bad_cs = 1;
                    if (mem_width != e.width) bad_width = 1;
                end
                if (e.write) begin
                    if (!mem_dout_en || mem_dout != e.wdata) bad_dout = 1;
                end else if (mem_dout_en) begin
                    bad_dout = 1;
                end
                if (strobe) begin
                    if (mem_cs_n == 8'hFF) bad_cs = 1;
                    s_cnt++;
                    if (e.write) begin
                        if (mem_we_n != ~e.be || !mem_oe_n) bad_sig = 1;
                    end else begin
                        if (mem_oe_n || mem_we_n != 4'hF) bad_sig = 1;
                    end
                    mem_din    = din_base + 32'(s_cnt);
                    mem_wait_n = (s_cnt >= wait_target);
                end else begin
                    mem_wait_n = 1'b1;
                    if (mem_cs_n == 8'hFF)  a_cnt++;
                    else if (s_cnt == 0)    c_cnt++;
                    else                    h_cnt++;
                end
            end
        end
    end

    task automatic write_cfg(int bank, bank_cfg_t c);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_bank = 3'(bank);
        cfg_data = c;
        @(negedge clk);
        cfg_wr   = 1'b0;
        cfgm[bank] = c;
    endtask

    // Driver: build the expected item from the bench's own view of the timing words.
    task automatic run_access(int bank, bit wr, logic [3:0] be, logic [31:0] wd,
                              int target, bit with_cfg, bank_cfg_t newc, bit poke);
        exp_t      e;
        bank_cfg_t c;
        int        base;
        while (!req_ready) @(negedge clk);
        c       = cfgm[bank];
        e.bank  = bank;
        e.write = wr;
        e.be    = be;
        e.wdata = wd;
        e.addr  = {3'(bank), 24'h00_1230 + 24'(bank)};
        e.tacs  = c.tacs;
        e.tcos  = c.rom ? 0 : int'(c.tcos);
        base    = (c.tacc == 0) ? 1 : int'(c.tacc);
        e.strobe = (target > base) ? target : base;
        e.stag  = (target > base) ? "R6" : "R5";
        e.hold  = c.tcoh;
        e.width = (bank == 0) ? strap_width0 : c.width;
        din_base = 32'h5A00_0000 ^ (32'(bank) << 16) ^ 32'(n_sent * 97);
        e.rdata = din_base + 32'(e.strobe);
        wait_target = target;
        sb_q.push_back(e);
        n_sent++;
        req_valid = 1'b1;
        req_write = wr;
        req_be    = be;
        req_wdata = wd;
        req_addr  = e.addr;
        if (with_cfg) begin
            cfg_wr   = 1'b1;
            cfg_bank = 3'(bank);
            cfg_data = newc;
        end
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr    = 1'b0;
        if (with_cfg) cfgm[bank] = newc;
        if (poke) begin
            // R11: requests while busy must be ignored
            @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b0;
            req_addr  = {3'd6, 24'h00_0040};
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
        compare("R8", "done low after completion", rsp_done, 0);
    endtask

    function automatic bank_cfg_t mk(int tacs, int tcos, int tacc, int tcoh, int rom, int width);
        bank_cfg_t c;
        c.tacs = 2'(tacs); c.tcos = 2'(tcos); c.tacc = 5'(tacc);
        c.tcoh = 2'(tcoh); c.rom = 1'(rom); c.width = 2'(width);
        return c;
    endfunction

    initial begin
        for (int b = 0; b < NB; b++) cfgm[b] = CFG_RESET;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "chip selects idle", mem_cs_n, 8'hFF);
        compare("R1", "output enable idle", mem_oe_n, 1);
        compare("R1", "write strobes idle", mem_we_n, 4'hF);
        compare("R1", "ready after reset", req_ready, 1);
        compare("R1", "done after reset", rsp_done, 0);

        // R1: reset timing word (3/ROM/31/3, width 11) on bank 1
        run_access(1, 0, 4'h0, 32'h0, 0, 0, '0, 0);

        // R3 R4 R5 R7 R10: ordinary bank
        write_cfg(3, mk(1, 2, 4, 2, 0, 1));
        run_access(3, 0, 4'h0, 32'h0, 0, 0, '0, 0);
        // R6: wait stretches past the 31-cycle ceiling
        run_access(3, 0, 4'h0, 32'h0, 40, 0, '0, 0);
        // R6: short stretch
        run_access(3, 0, 4'h0, 32'h0, 6, 0, '0, 0);
        // R9: write with partial lanes
        run_access(3, 1, 4'b0101, 32'hCAFE_F00D, 0, 0, '0, 0);

        // zero-length phases
        write_cfg(4, mk(0, 0, 0, 0, 0, 2));
        run_access(4, 0, 4'h0, 32'h0, 0, 0, '0, 0);
        run_access(4, 1, 4'b1110, 32'h1357_9BDF, 0, 0, '0, 0);
        run_access(4, 0, 4'h0, 32'h0, 3, 0, '0, 0);

        // R4: ROM bank skips select lead even with tcos programmed
        write_cfg(5, mk(0, 3, 2, 1, 1, 3));
        run_access(5, 0, 4'h0, 32'h0, 0, 0, '0, 0);

        // R10: bank 0 width from straps
        write_cfg(0, mk(1, 1, 2, 1, 0, 0));
        strap_width0 = 2'b01;
        run_access(0, 0, 4'h0, 32'h0, 0, 0, '0, 0);
        strap_width0 = 2'b10;
        run_access(0, 1, 4'b1111, 32'hA5A5_5A5A, 0, 0, '0, 0);

        // R12: config write on the same edge as acceptance
        run_access(3, 0, 4'h0, 32'h0, 0, 1, mk(3, 0, 9, 3, 0, 2), 0);
        run_access(3, 0, 4'h0, 32'h0, 0, 0, '0, 0);

        // R11: requests while busy
        write_cfg(2, mk(1, 1, 12, 1, 0, 3));
        run_access(2, 0, 4'h0, 32'h0, 0, 0, '0, 1);
        repeat (3) begin
            @(negedge clk);
            compare("R11", "ready stays idle", req_ready, 1);
            compare("R11", "no chip select", mem_cs_n, 8'hFF);
        end
        compare("R11", "completions equal requests", n_done, n_sent);
        compare("R11", "scoreboard drained", sb_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule